// File: doc/BRIEF.md
# Serial Control Register Slave

This block is the slave end of a shared four-wire control port on a peripheral chip. The host lowers an active-low select, clocks bits on a serial clock and drives a command line; the block answers on a reply line. The first byte of every transaction is an address, and that address alone decides what follows. It may be a data byte from the host into a control register, a data byte returned to the host, or nothing. There is no direction bit in the address. One address is a bare command that clears the control registers and raises a one-cycle reset output for the rest of the chip.

All serial inputs are brought into the block's own clock domain through synchronizers. Serial clock edges are found by comparing two successive synchronized samples. Several slaves can share the select, clock, command and reply lines. Addresses the block does not own pass by with no effect, and the reply line stays low for them. An active-low disable input (the enable port held high for normal use) shuts the whole port.

Top module: `serctl_slave`

## Requirements
- R1: After a synchronous reset both control registers read 0x00, and the reply output and the reset output are low.
- R2: Address 0x1B followed by a data byte loads that byte into control register A. Address 0x1E does the same for control register B. Bits arrive MSB first on the command input and are taken on the rising serial clock edge. The register changes only once all eight data bits are in.
- R3: Address 0xEB returns control register A and address 0xEE returns control register B on the reply output. The value goes out MSB first, and each bit is presented after a falling serial clock edge in the data byte.
- R4: Address 0x1A, with no data byte, clears both control registers to 0x00 and drives the reset output high for exactly one clock cycle. It takes effect on the eighth address bit.
- R5: Any address other than 0x1A, 0x1B, 0x1E, 0xEB and 0xEE leaves both registers unchanged, gives no reset pulse, and keeps the reply output low.
- R6: Raising the select before a transaction completes discards it: a partial data byte is never written, and the next transaction starts framing at a fresh address byte.
- R7: While the enable input is low, no transaction writes, clears, pulses or replies.
- R8: The reply output is low during the address byte and whenever no read data byte is in progress.
- R9: Once a transaction is complete, further clock bits before the select is raised are ignored. They are not taken as a new address, and they are not taken as more data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| port_on | input | 1 | Serial port enable; low disables the port |
| sel_n | input | 1 | Active-low transaction select from host |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Command data from host, MSB first |
| sdo | output | 1 | Reply data to host, MSB first |
| ctrl_a | output | 8 | Control register A (written at 0x1B, read at 0xEB) |
| ctrl_b | output | 8 | Control register B (written at 0x1E, read at 0xEE) |
| gen_rst | output | 1 | One-cycle general reset pulse |

## Verification
The assertions watch, on every cycle, the following properties:
- the reset output never lasts longer than one cycle;
- a clear really zeroes both registers;
- the registers only move on a write strobe or a clear;
- each write strobe selects exactly one register;
- a deselected or disabled port leaves the reply low and issues no strobe;
- the bit counter returns to zero whenever the port is idle.

Only the bench scenarios can show the following:
- a byte sent serially lands in the right register with the right bit order;
- the read-back value appears bit by bit on the falling edges;
- every foreign address out of all 256 is ignored;
- aborted and over-long transactions are handled as R6 and R9 require.

// File: rtl/serctl_pkg.sv
// Package serctl_pkg
// Shared types and address constants for the serial control register slave.
// Assumes an 8-bit address byte; the addresses are fixed by the chip's map.
package serctl_pkg;

    // Decoded meaning of a received address byte
    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_RESET,
        CMD_WR_A,
        CMD_WR_B,
        CMD_RD_A,
        CMD_RD_B
    } cmd_e;

    // Position of the frame within the current transaction
    typedef enum logic [1:0] {
        PH_ADDR,
        PH_WRITE,
        PH_READ,
        PH_DONE
    } phase_e;

    localparam int          ADDR_W     = 8;
    localparam logic [7:0]  ADR_GRESET = 8'h1A;
    localparam logic [7:0]  ADR_WR_A   = 8'h1B;
    localparam logic [7:0]  ADR_WR_B   = 8'h1E;
    localparam logic [7:0]  ADR_RD_A   = 8'hEB;
    localparam logic [7:0]  ADR_RD_B   = 8'hEE;

endpackage

// File: rtl/serctl_sync.sv
// Module serctl_sync
// Multi-stage synchronizer for a vector of asynchronous inputs.
// It also keeps one extra stage so that edges can be detected.
// Assumes every input is held for more than STAGES+1 clock cycles per level.
module serctl_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] dout_prev
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0][W-1:0] stg;

    // Shift the inputs through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= {DEPTH{RST_VAL}};
        end else begin
            stg <= {stg[DEPTH-2:0], din};
        end
    end

    assign dout      = stg[STAGES-1];
    assign dout_prev = stg[STAGES];

endmodule

// File: rtl/serctl_decode.sv
// Module serctl_decode
// Combinational map from an address byte to a command.
// Direction comes from the address alone; there is no read/write bit.
// An address that is not in the map decodes to CMD_NONE.
module serctl_decode
    import serctl_pkg::*;
#(
    parameter int              AW     = ADDR_W,
    parameter logic [AW-1:0]   A_RST  = AW'(ADR_GRESET),
    parameter logic [AW-1:0]   A_WR_A = AW'(ADR_WR_A),
    parameter logic [AW-1:0]   A_WR_B = AW'(ADR_WR_B),
    parameter logic [AW-1:0]   A_RD_A = AW'(ADR_RD_A),
    parameter logic [AW-1:0]   A_RD_B = AW'(ADR_RD_B)
) (
    input  logic [AW-1:0] addr,
    output cmd_e          cmd
);

    // Compare the address against each owned location
    always_comb begin
        if (addr == A_RST)       cmd = CMD_RESET;
        else if (addr == A_WR_A) cmd = CMD_WR_A;
        else if (addr == A_WR_B) cmd = CMD_WR_B;
        else if (addr == A_RD_A) cmd = CMD_RD_A;
        else if (addr == A_RD_B) cmd = CMD_RD_B;
        else                     cmd = CMD_NONE;
    end

endmodule

// File: rtl/serctl_frame.sv
// Module serctl_frame
// Transaction framer. It shifts in the address byte and decodes it.
// It then either collects a write byte, shifts out a read byte, or issues the
// clear command. Once the transaction is complete, it ignores the serial
// clock until the port goes idle.
// Assumes single-cycle sck_rise/sck_fall strobes that never coincide.
// Assumes sdi_bit is stable at each rise strobe.
module serctl_frame
    import serctl_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          sdi_bit,
    input  logic [DW-1:0] rd_a,
    input  logic [DW-1:0] rd_b,
    output logic          wr_stb,
    output logic [1:0]    wr_sel,
    output logic [DW-1:0] wr_data,
    output logic          clr,
    output logic          sdo
);
    localparam int            CW   = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    phase_e        phase;
    logic [CW-1:0] cnt;
    logic [DW-1:0] shreg;
    logic [DW-1:0] txreg;
    logic [DW-1:0] word_in;
    logic          last_bit;
    cmd_e          cmd;

    assign word_in  = {shreg[DW-2:0], sdi_bit};
    assign last_bit = (cnt == LAST);

    serctl_decode #(
        .AW (DW)
    ) u_decode (
        .addr (word_in),
        .cmd  (cmd)
    );

    // Framing state machine: shift, count, decode, strobe and reply
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_ADDR;
            cnt     <= '0;
            shreg   <= '0;
            txreg   <= '0;
            wr_stb  <= 1'b0;
            wr_sel  <= '0;
            wr_data <= '0;
            clr     <= 1'b0;
            sdo     <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            clr    <= 1'b0;
            if (!active) begin
                phase <= PH_ADDR;
                cnt   <= '0;
                sdo   <= 1'b0;
            end else if (sck_rise) begin
                unique case (phase)
                    PH_ADDR: begin
                        shreg <= word_in;
                        cnt   <= cnt + CW'(1);
                        if (last_bit) begin
                            cnt <= '0;
                            case (cmd)
                                CMD_RESET: begin
                                    clr   <= 1'b1;
                                    phase <= PH_DONE;
                                end
                                CMD_WR_A: begin
                                    wr_sel <= 2'b01;
                                    phase  <= PH_WRITE;
                                end
                                CMD_WR_B: begin
                                    wr_sel <= 2'b10;
                                    phase  <= PH_WRITE;
                                end
                                CMD_RD_A: begin
                                    txreg <= rd_a;
                                    phase <= PH_READ;
                                end
                                CMD_RD_B: begin
                                    txreg <= rd_b;
                                    phase <= PH_READ;
                                end
                                default: phase <= PH_DONE;
                            endcase
                        end
                    end
                    PH_WRITE: begin
                        shreg <= word_in;
                        cnt   <= cnt + CW'(1);
                        if (last_bit) begin
                            cnt     <= '0;
                            wr_stb  <= 1'b1;
                            wr_data <= word_in;
                            phase   <= PH_DONE;
                        end
                    end
                    PH_READ: begin
                        cnt <= cnt + CW'(1);
                        if (last_bit) begin
                            cnt   <= '0;
                            sdo   <= 1'b0;
                            phase <= PH_DONE;
                        end
                    end
                    PH_DONE: begin
                    end
                endcase
            end else if (sck_fall && phase == PH_READ) begin
                sdo   <= txreg[DW-1];
                txreg <= {txreg[DW-2:0], 1'b0};
            end
        end
    end

    // R6: an idle or aborted port always restarts its bit count from zero
    assert_idle_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt == '0));

    // R4: the clear command never lasts more than one cycle
    assert_clear_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !clr);

    // R9: strobes only appear as a transaction completes, never in the address phase
    assert_strobe_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb || clr) |-> (phase == PH_DONE));

endmodule

// File: rtl/serctl_regfile.sv
// Module serctl_regfile
// Writable control registers. Each register loads on a write strobe that
// selects it, and all registers clear together on the clear command.
// Assumes wr_sel is one-hot whenever wr_stb is high.
module serctl_regfile #(
    parameter int DW   = 8,
    parameter int NREG = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     wr_stb,
    input  logic [NREG-1:0]          wr_sel,
    input  logic [DW-1:0]            wr_data,
    output logic [NREG-1:0][DW-1:0]  regs
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Hold, load or clear one control register
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (clr) begin
                regs[g] <= '0;
            end else if (wr_stb && wr_sel[g]) begin
                regs[g] <= wr_data;
            end
        end

        // R4: a clear leaves the register at zero
        assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (regs[g] == '0));

        // R2: without a strobe or clear aimed at it, the register keeps its value
        assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !(clr || (wr_stb && wr_sel[g])) |=> $stable(regs[g]));
    end

    // R2: every write strobe selects exactly one register
    assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ($countones(wr_sel) == 1));

endmodule

// File: rtl/serctl_slave.sv
// Module serctl_slave
// Top of the serial control register slave. It synchronizes the port pins,
// detects serial clock edges, frames transactions and holds the control
// registers. Assumes each serial clock level lasts at least four clk cycles.
module serctl_slave
    import serctl_pkg::*;
#(
    parameter int DW     = 8,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          port_on,
    input  logic          sel_n,
    input  logic          sclk,
    input  logic          sdi,
    output logic          sdo,
    output logic [DW-1:0] ctrl_a,
    output logic [DW-1:0] ctrl_b,
    output logic          gen_rst
);
    localparam int NPIN = 4;
    localparam int NREG = 2;
    localparam logic [NPIN-1:0] PIN_IDLE = 4'b0001;

    logic [NPIN-1:0]          pins_s;
    logic [NPIN-1:0]          pins_p;
    logic                     port_on_s;
    logic                     sel_n_s;
    logic                     sclk_s;
    logic                     sclk_p;
    logic                     sdi_s;
    logic                     active;
    logic                     sck_rise;
    logic                     sck_fall;
    logic                     wr_stb;
    logic [1:0]               wr_sel;
    logic [DW-1:0]            wr_data;
    logic                     clr;
    logic [NREG-1:0][DW-1:0]  regs;

    serctl_sync #(
        .W       (NPIN),
        .STAGES  (STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       ({port_on, sdi, sclk, sel_n}),
        .dout      (pins_s),
        .dout_prev (pins_p)
    );

    assign sel_n_s   = pins_s[0];
    assign sclk_s    = pins_s[1];
    assign sdi_s     = pins_s[2];
    assign port_on_s = pins_s[3];
    assign sclk_p    = pins_p[1];

    assign active   = port_on_s && !sel_n_s;
    assign sck_rise = sclk_s && !sclk_p;
    assign sck_fall = !sclk_s && sclk_p;

    serctl_frame #(
        .DW (DW)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sdi_bit  (sdi_s),
        .rd_a     (regs[0]),
        .rd_b     (regs[1]),
        .wr_stb   (wr_stb),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .clr      (clr),
        .sdo      (sdo)
    );

    serctl_regfile #(
        .DW   (DW),
        .NREG (NREG)
    ) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .wr_stb  (wr_stb),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .regs    (regs)
    );

    assign ctrl_a  = regs[0];
    assign ctrl_b  = regs[1];
    assign gen_rst = clr;

    // R8: a deselected or disabled port drives the reply low
    assert_reply_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !sdo);

    // R7: a disabled port issues neither a write nor a clear
    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !port_on_s |=> !(wr_stb || clr));

endmodule

// File: tb/test_serctl_slave.sv
`timescale 1ns/1ps
module test_serctl_slave;
    localparam int H = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic port_on = 1'b1;
    logic sel_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo;
    logic [7:0] ctrl_a;
    logic [7:0] ctrl_b;
    logic gen_rst;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    serctl_slave i_serctl_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .port_on (port_on),
        .sel_n   (sel_n),
        .sclk    (sclk),
        .sdi     (sdi),
        .sdo     (sdo),
        .ctrl_a  (ctrl_a),
        .ctrl_b  (ctrl_b),
        .gen_rst (gen_rst)
    );

    // count reset-output cycles
    always @(negedge clk) if (gen_rst) pulses++;

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // send the low n bits of 'bits' MSB first; record sdo before each rising edge
    task automatic frame(input logic [23:0] bits, input int n, output logic [23:0] seen);
        seen = '0;
        sel_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            sclk = 1'b0;
            sdi = bits[n-1-i];
            wait_clk(H);
            @(negedge clk);
            seen[n-1-i] = sdo;
            @(posedge clk);
            #1;
            sclk = 1'b1;
            wait_clk(H);
        end
        sel_n = 1'b1;
        wait_clk(2);
        sclk = 1'b0;
        sdi = 1'b0;
        wait_clk(6);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        logic [23:0] s;
        frame({8'h00, a, d}, 16, s);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v, output logic [7:0] ahead);
        logic [23:0] s;
        frame({8'h00, a, 8'h00}, 16, s);
        v = s[7:0];
        ahead = s[15:8];
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] ah;
        logic [7:0] exp_b;
        logic [23:0] s;
        int p0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);

        // R1 reset state
        check(ctrl_a == 8'h00, "R1", "ctrl_a", ctrl_a, 0);
        check(ctrl_b == 8'h00, "R1", "ctrl_b", ctrl_b, 0);
        check(sdo == 1'b0, "R1", "sdo", sdo, 0);
        check(pulses == 0, "R1", "gen_rst", pulses, 0);

        // R2/R3/R8 sweep of register A over all values
        for (int x = 0; x < 256; x++) begin
            wr(8'h1B, 8'(x));
            check(ctrl_a == 8'(x), "R2", "ctrl_a write", ctrl_a, x);
            rd(8'hEB, v, ah);
            check(v == 8'(x), "R3", "read 0xEB", v, x);
            check(ah == 8'h00, "R8", "sdo in address byte", ah, 0);
        end
        check(ctrl_b == 8'h00, "R2", "ctrl_b untouched by A writes", ctrl_b, 0);

        // R2/R3 register B over a spread of values
        for (int k = 0; k < 16; k++) begin
            exp_b = 8'(k * 17) ^ 8'h96;
            wr(8'h1E, exp_b);
            check(ctrl_b == exp_b, "R2", "ctrl_b write", ctrl_b, exp_b);
            rd(8'hEE, v, ah);
            check(v == exp_b, "R3", "read 0xEE", v, exp_b);
        end
        check(ctrl_a == 8'hFF, "R2", "ctrl_a untouched by B writes", ctrl_a, 8'hFF);

        // R9 extra byte after a complete write is ignored
        frame({8'h1B, 8'h11, 8'h22}, 24, s);
        check(ctrl_a == 8'h11, "R9", "ctrl_a after overlong write", ctrl_a, 8'h11);
        check(ctrl_b == exp_b, "R9", "ctrl_b after overlong write", ctrl_b, exp_b);
        // R8/R9 reply goes low after the read byte
        frame({8'hEB, 8'h00, 8'h00}, 24, s);
        check(s[15:8] == 8'h11, "R3", "read in long frame", s[15:8], 8'h11);
        check(s[7:0] == 8'h00, "R8", "sdo after read byte", s[7:0], 0);

        // R6 abort during data and during address
        wr(8'h1B, 8'h5A);
        frame({12'h000, 8'h1B, 4'hF}, 12, s);
        check(ctrl_a == 8'h5A, "R6", "ctrl_a after aborted write", ctrl_a, 8'h5A);
        frame({20'h0, 4'h1}, 4, s);
        wr(8'h1E, 8'h77);
        check(ctrl_b == 8'h77, "R6", "ctrl_b after aborted address", ctrl_b, 8'h77);

        // R4 general reset command
        p0 = pulses;
        frame({16'h0, 8'h1A}, 8, s);
        check(pulses - p0 == 1, "R4", "reset pulse cycles", pulses - p0, 1);
        check(ctrl_a == 8'h00, "R4", "ctrl_a cleared", ctrl_a, 0);
        check(ctrl_b == 8'h00, "R4", "ctrl_b cleared", ctrl_b, 0);
        wr(8'h1B, 8'h44);
        p0 = pulses;
        frame({8'h00, 8'h1A, 8'h1B}, 16, s);
        check(pulses - p0 == 1, "R4", "reset pulse with trailing byte", pulses - p0, 1);
        check(ctrl_a == 8'h00, "R9", "trailing byte after reset ignored", ctrl_a, 0);

        // R5 sweep of every foreign address
        wr(8'h1B, 8'hC3);
        wr(8'h1E, 8'h3C);
        p0 = pulses;
        for (int a = 0; a < 256; a++) begin
            if (a == 8'h1A || a == 8'h1B || a == 8'h1E || a == 8'hEB || a == 8'hEE) continue;
            frame({8'h00, 8'(a), 8'hA5}, 16, s);
            check(ctrl_a == 8'hC3 && ctrl_b == 8'h3C && s == 24'h0, "R5",
                  $sformatf("foreign addr %0h regs/sdo", a), {ctrl_a, ctrl_b, s[15:0]}, 32'hC33C0000);
        end
        check(pulses == p0, "R5", "no reset pulse on foreign", pulses - p0, 0);

        // R7 disabled port
        port_on = 1'b0;
        wait_clk(6);
        wr(8'h1B, 8'h99);
        check(ctrl_a == 8'hC3, "R7", "write while disabled", ctrl_a, 8'hC3);
        p0 = pulses;
        frame({16'h0, 8'h1A}, 8, s);
        check(pulses == p0 && ctrl_b == 8'h3C, "R7", "reset while disabled", pulses - p0, 0);
        rd(8'hEB, v, ah);
        check(v == 8'h00, "R7", "reply while disabled", v, 0);
        port_on = 1'b1;
        wait_clk(6);
        rd(8'hEB, v, ah);
        check(v == 8'hC3, "R7", "read after re-enable", v, 8'hC3);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule